// File: doc/BRIEF.md
# Slow Parallel Byte Bus Transmitter

This block sends a stored message over a nine-line parallel bus that carries data in one direction only. Eight lines hold the bits of one byte, and a ninth line is a strobe that marks when the byte is valid. The bus is meant for receivers that react slowly, such as lines that drive mechanical actuators. A high level on a line drives that line active.

A loader first fills an on-chip single-port buffer through a write port. A start request then gives the number of bytes to send and three phase lengths, all counted in system clocks:

- how long the data settles before the strobe rises;
- how long the strobe stays high;
- how long the data is held after the strobe falls.

The transmitter reads the buffer back one byte at a time, from address 0 upward, and shows each byte on the data lines. It raises the strobe exactly once per byte. `busy` stays high for the whole transfer. When the last byte has been sent, `done` pulses for one cycle.

Top module: `slow_bus_tx`

## Requirements
- R1: Bytes are sent in address order 0 to N-1, where N is the byte count given with the start request. Bit k of a buffer word drives `bus_data[k]`.
- R2: The strobe goes high exactly once per byte, so a transfer makes exactly N strobe pulses.
- R3: Each byte sits on the data lines, with the strobe low, for max(S,1) cycles before the strobe rises. S is the settle length.
- R4: The strobe stays high for max(P,1) cycles, and the data lines do not change while it is high. P is the strobe length.
- R5: After the strobe falls, the data stays unchanged for max(H,1) cycles, where H is the hold length. The next byte then appears exactly two cycles later, after a buffer read and a load.
- R6: A start seen in a clock edge, while idle and with N not zero, raises `busy` in the next cycle. The first byte appears two cycles after that.
- R7: Buffer writes are accepted only while idle. A write while `busy` is high leaves the buffer unchanged.
- R8: A start request while `busy` is high is ignored. The running transfer keeps its own byte count.
- R9: In the cycle after the last hold cycle, all nine lines are low, `busy` is low and `done` is high. `done` is high for that one cycle only.
- R10: A start request with N = 0 is ignored: `busy` stays low and `done` does not pulse.
- R11: While reset is held, all nine bus lines, `busy` and `done` are low.
- R12: The byte count and the three phase lengths are captured when a transfer starts. Changing those inputs during the transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Buffer write enable, honoured only while idle |
| wr_addr | input | ADDR_W | Buffer write address |
| wr_data | input | DATA_W | Buffer write data |
| start | input | 1 | Transfer request |
| byte_count | input | ADDR_W+1 | Number of bytes to send, 0 to DEPTH |
| settle_len | input | CNT_W | Data settle time before the strobe rises, in cycles |
| strobe_len | input | CNT_W | Strobe high time, in cycles |
| hold_len | input | CNT_W | Data hold time after the strobe falls, in cycles |
| bus_data | output | DATA_W | Data lines |
| bus_strobe | output | 1 | Strobe line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |

## Verification
The bench builds the block with DEPTH = 16 and CNT_W = 6. A full-buffer transfer of 16 bytes then takes only a few hundred cycles, so the last address and the widest byte count are both exercised. The narrow timer also puts the largest phase length, 63 cycles, within reach. Zero phase lengths are run as well, to cover the one-cycle floor on each phase.

// File: rtl/slow_bus_tx.sv
module slow_bus_tx #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic [LEN_W-1:0]  byte_count,
  input  logic [CNT_W-1:0]  settle_len,
  input  logic [CNT_W-1:0]  strobe_len,
  input  logic [CNT_W-1:0]  hold_len,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_strobe,
  output logic              busy,
  output logic              done
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOAD, S_SETTLE, S_STROBE, S_HOLD} state_t;

  state_t            state;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q, data_r;
  logic [LEN_W-1:0]  idx, len;
  logic [CNT_W-1:0]  t_settle, t_strobe, t_hold, timer, phase_len;
  logic              done_r, last;
  logic [ADDR_W-1:0] addr;

  assign addr = (state == S_IDLE) ? wr_addr : idx[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en && state == S_IDLE) mem[addr] <= wr_data;
    else                          rd_q      <= mem[addr];
  end

  always_comb begin
    case (state)
      S_SETTLE: phase_len = t_settle;
      S_STROBE: phase_len = t_strobe;
      default:  phase_len = t_hold;
    endcase
  end

  assign last = ({1'b0, timer} + (CNT_W+1)'(1)) >= {1'b0, phase_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      len      <= '0;
      t_settle <= '0;
      t_strobe <= '0;
      t_hold   <= '0;
      timer    <= '0;
      data_r   <= '0;
      done_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (state)
        S_IDLE: if (start && byte_count != '0) begin
          len      <= byte_count;
          t_settle <= settle_len;
          t_strobe <= strobe_len;
          t_hold   <= hold_len;
          idx      <= '0;
          state    <= S_FETCH;
        end
        S_FETCH: state <= S_LOAD;
        S_LOAD: begin
          data_r <= rd_q;
          timer  <= '0;
          state  <= S_SETTLE;
        end
        S_SETTLE, S_STROBE: begin
          if (last) begin
            timer <= '0;
            state <= (state == S_SETTLE) ? S_STROBE : S_HOLD;
          end else begin
            timer <= timer + CNT_W'(1);
          end
        end
        S_HOLD: begin
          if (last) begin
            timer <= '0;
            if (idx + LEN_W'(1) == len) begin
              state  <= S_IDLE;
              data_r <= '0;
              done_r <= 1'b1;
            end else begin
              idx   <= idx + LEN_W'(1);
              state <= S_FETCH;
            end
          end else begin
            timer <= timer + CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_data   = data_r;
  assign bus_strobe = (state == S_STROBE);
  assign busy       = (state != S_IDLE);
  assign done       = done_r;

endmodule

module slow_bus_tx_chk #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LEN_W-1:0]  byte_count,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_strobe,
  input logic              busy,
  input logic              done
);

  p_strobe_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> $stable(bus_data));

  p_strobe_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> busy);

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count != '0) |=> busy);

  p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && byte_count == '0) |=> (!busy && !done));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_strobe && bus_data == '0));

  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_strobe && bus_data == '0));

endmodule

bind slow_bus_tx slow_bus_tx_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
  .bus_data(bus_data), .bus_strobe(bus_strobe), .busy(busy), .done(done));

// File: tb/slow_bus_tx_tb_top.sv
`timescale 1ns/1ps
module slow_bus_tx_tb_top;
  localparam int DW = 8, DEPTH = 16, CW = 6, AW = 4, LW = 5;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] byte_count = '0;
  logic [CW-1:0] settle_len = '0, strobe_len = '0, hold_len = '0;
  logic [DW-1:0] bus_data;
  logic bus_strobe, busy, done;

  always #4 clk = ~clk;

  slow_bus_tx #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .byte_count(byte_count), .settle_len(settle_len),
    .strobe_len(strobe_len), .hold_len(hold_len), .bus_data(bus_data),
    .bus_strobe(bus_strobe), .busy(busy), .done(done));

  int checks = 0, fails = 0, cyc = 0;
  int pulses = 0, cur_w = 0, last_w = 0;
  logic prev_strobe = 0;
  logic [DW-1:0] strobe_data = '0;
  logic [DW-1:0] mdl_mem [DEPTH];
  logic [DW+2:0] expq [$];
  logic [DW+2:0] exp_now = '0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int ph(int n);
    return (n == 0) ? 1 : n;
  endfunction

  // Reference model: on an accepted start the whole expected trace is queued.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      expq.delete();
      exp_now = '0;
    end else begin
      if (expq.size() == 0) begin
        if (wr_en) mdl_mem[wr_addr] = wr_data;
        if (start && byte_count != 0) begin
          logic [DW-1:0] prev;
          prev = '0;
          for (int i = 0; i < int'(byte_count); i++) begin
            logic [DW-1:0] d;
            d = mdl_mem[i];
            repeat (2) expq.push_back({1'b1, 1'b0, 1'b0, prev});
            repeat (ph(int'(settle_len))) expq.push_back({1'b1, 1'b0, 1'b0, d});
            repeat (ph(int'(strobe_len))) expq.push_back({1'b1, 1'b0, 1'b1, d});
            repeat (ph(int'(hold_len)))   expq.push_back({1'b1, 1'b0, 1'b0, d});
            prev = d;
          end
          expq.push_back({1'b0, 1'b1, 1'b0, {DW{1'b0}}});
        end
      end
      exp_now = (expq.size() != 0) ? expq.pop_front() : '0;
    end
  end

  always @(negedge clk) begin
    chk({busy, done, bus_strobe, bus_data} == exp_now,
        "R1 R3 R4 R5 R6 R9 per-cycle trace", {busy, done, bus_strobe, bus_data}, exp_now);
    if (bus_strobe && !prev_strobe) begin
      pulses++;
      strobe_data = bus_data;
      cur_w = 0;
    end
    if (bus_strobe) cur_w++;
    if (!bus_strobe && prev_strobe) last_w = cur_w;
    prev_strobe = bus_strobe;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic load(int seed);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = AW'(a); wr_data = DW'(a * 37 + seed);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send(int cnt, int s, int p, int h);
    @(negedge clk);
    start = 1; byte_count = LW'(cnt);
    settle_len = CW'(s); strobe_len = CW'(p); hold_len = CW'(h);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, bus_strobe, bus_data} == '0, "R11 reset state",
        {busy, done, bus_strobe, bus_data}, 0);
    rst_n = 1;

    load(5);
    pulses = 0;
    send(3, 2, 3, 1);
    wait_done();
    chk(pulses == 3, "R2 pulse count", pulses, 3);

    pulses = 0;
    send(4, 0, 0, 0);
    wait_done();
    chk(pulses == 4, "R2 zero-length phases", pulses, 4);

    load(11);
    pulses = 0;
    send(16, 1, 1, 1);
    wait_done();
    chk(pulses == 16, "R1 R2 full buffer", pulses, 16);

    pulses = 0;
    send(5, 1, 2, 1);
    @(negedge clk);
    start = 1; byte_count = 2; wr_en = 1; wr_addr = 0; wr_data = 8'hAA;
    settle_len = 9; strobe_len = 9; hold_len = 9;
    @(negedge clk);
    start = 0; wr_en = 0;
    wait_done();
    chk(pulses == 5, "R8 start while busy", pulses, 5);
    chk(last_w == 2, "R12 latched strobe length", last_w, 2);

    send(1, 1, 1, 1);
    wait_done();
    chk(strobe_data == DW'(11), "R7 write while busy", strobe_data, 11);

    send(0, 1, 1, 1);
    for (int i = 0; i < 3; i++) begin
      chk(!busy && !done, "R10 zero count", {busy, done}, 0);
      @(negedge clk);
    end

    pulses = 0;
    send(2, 0, 63, 2);
    while (!done) @(negedge clk);
    start = 1; byte_count = 1; settle_len = 1; strobe_len = 1; hold_len = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R6 start in done cycle", busy, 1);
    wait_done();
    chk(pulses == 3, "R2 back-to-back", pulses, 3);
    chk(last_w == 1, "R4 strobe length", last_w, 1);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule